// File: doc/BRIEF.md
# Local Configuration Control Register

This block is a single 32-bit control and status word for device housekeeping. It sits on a plain host register bus. Two write strobes reach it. The I/O strobe accepts one byte per access. The memory strobe accepts any mix of byte enables. The word is always visible on a combinational read port.

The same word mixes several kinds of bit:

- Live readback of two mode strap pins.
- An enable for a glitch-free gated copy of the clock.
- A two-bit lane select that steers 8-bit peripheral traffic onto one byte of the 32-bit bus.
- Directly driven pins that let software bit-bang a serial configuration EEPROM.
- A self-clearing reload request served by a small loader model.

The lane steering is combinational. In narrow mode a peripheral byte read is placed on the selected lane. A host dword write has its selected byte pulled down to bits 7:0. When the local bus runs in 32-bit mode, both paths pass data through unchanged. The loader model counts a fixed number of cycles after a reload request and then pulses its done output. That pulse clears the request bit.

Top module: `local_ctl_reg`

## Requirements
- R1: After reset the register reads 0 in every stored bit, `clk_out` stays low, and `ee_clk`, `ee_cs` and `ee_dout` are 0.
- R2: Read bits 1:0 always equal `mode_strap`. Writes to them have no effect.
- R3: Bit 2 enables `clk_out`. While the enable is 0, `clk_out` is constantly low. Once it is 1, the enable is latched on the falling clock edge and `clk_out` copies the clock from the next high phase onward.
- R4: Bits 4:3 pick the lane, with 0 for bits 7:0, 1 for 15:8, 2 for 23:16 and 3 for 31:24. With `pb_wide`=0, `steer_rdata` carries `pb_rdata[7:0]` on the picked lane and zeros elsewhere. In the same mode `pb_wdata` carries the picked byte of `bus_wdata` in bits 7:0 and zeros above.
- R5: With `pb_wide`=1 the lane field is ignored: `steer_rdata` equals `pb_rdata` and `pb_wdata` equals `bus_wdata`.
- R6: Bits 24, 25 and 26 are read/write and drive `ee_clk`, `ee_cs` (active high) and `ee_dout` respectively.
- R7: Read bit 27 follows `ee_din` and read bit 28 follows `ee_image_ok`. Writes to both have no effect.
- R8: Writing 1 to bit 29 while it is 0 starts a reload: the bit reads 1 for exactly LOAD_CYCLES cycles, and `reload_done` pulses in the last of them. Writing 0 has no effect. Writing 1 while a reload is running neither restarts nor extends it.
- R9: Bits 23:8 are read/write storage that resets to 0. Bits 31:30 and 7:5 always read 0.
- R10: An I/O write (`bus_io_wr`) with other than exactly one bit of `bus_be` set changes no stored bit. With exactly one bit set, only that byte is updated.
- R11: A memory write (`bus_mem_wr`) updates every byte whose `bus_be` bit is 1 and leaves the other bytes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock, also the source of `clk_out` |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_io_wr | input | 1 | I/O-path write strobe (single byte only) |
| bus_mem_wr | input | 1 | Memory-path write strobe |
| bus_be | input | 4 | Byte enables for the write |
| bus_wdata | input | 32 | Write data, also the source of peripheral write steering |
| bus_rdata | output | 32 | Register read value |
| mode_strap | input | 2 | Mode strap pins |
| clk_out | output | 1 | Gated clock output |
| pb_wide | input | 1 | Local bus is in 32-bit mode |
| pb_rdata | input | 32 | Data returned by the peripheral bus |
| pb_wdata | output | 32 | Steered write data toward the peripheral bus |
| steer_rdata | output | 32 | Steered read data toward the host |
| ee_clk | output | 1 | EEPROM clock pin |
| ee_cs | output | 1 | EEPROM chip select, active high |
| ee_dout | output | 1 | Data toward the EEPROM |
| ee_din | input | 1 | Data from the EEPROM |
| ee_image_ok | input | 1 | A valid EEPROM image is present |
| reload_done | output | 1 | One-cycle pulse when a reload finishes |

## Verification
Register writes are driven at random through both strobes, with random byte-enable masks. Masks with zero, one and several bits set separate the single-byte I/O rule from the per-byte memory rule. The strap, EEPROM data-in and image-valid inputs change between writes, which shows that those bits are live and not stored. Lane steering is tried in all four lane codes in both bus modes with random data, so a wrong lane, leaked upper bytes or a missed pass-through each give a distinct mismatch. Directed cases cover the clock gate in both states, and the reload length when a second request arrives mid-load or a 0 is written.

// File: rtl/lcc_pkg.sv
package lcc_pkg;
  localparam int unsigned LCC_W      = 32;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned N_BYTES    = LCC_W / BYTE_W;
  localparam int unsigned SEL_W      = $clog2(N_BYTES);
  localparam int unsigned RSV_LO     = 8;
  localparam int unsigned RSV_W      = 16;
  localparam int unsigned B_CLKEN    = 2;
  localparam int unsigned B_LANE     = 3;
  localparam int unsigned B_EECLK    = 24;
  localparam int unsigned B_EECS     = 25;
  localparam int unsigned B_EEDO     = 26;
  localparam int unsigned B_EEDI     = 27;
  localparam int unsigned B_IMGOK    = 28;
  localparam int unsigned B_RELOAD   = 29;

  typedef struct packed {
    logic             clk_en;
    logic [SEL_W-1:0] lane;
    logic [RSV_W-1:0] rsv;
    logic             ee_ck;
    logic             ee_cs;
    logic             ee_do;
    logic             reload;
  } lcc_state_t;

  function automatic logic one_hot(input logic [N_BYTES-1:0] v);
    return (v != '0) && ((v & (v - 1'b1)) == '0);
  endfunction
endpackage

// File: rtl/lcc_regfile.sv
module lcc_regfile
  import lcc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               io_wr,
  input  logic               mem_wr,
  input  logic [N_BYTES-1:0] be,
  input  logic [LCC_W-1:0]   wdata,
  input  logic [1:0]         strap,
  input  logic               ee_di,
  input  logic               img_ok,
  input  logic               load_done,
  output lcc_state_t         st,
  output logic [LCC_W-1:0]   rdata,
  output logic               load_kick
);
  logic [N_BYTES-1:0] byte_we;
  lcc_state_t         st_q;

  // I/O path: exactly one lane, else dropped. Memory path: any lanes.
  always_comb begin
    byte_we = '0;
    if (mem_wr)                      byte_we = be;
    else if (io_wr && one_hot(be))   byte_we = be;
  end

  assign load_kick = byte_we[3] && wdata[B_RELOAD] && !st_q.reload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else begin
      if (byte_we[0]) begin
        st_q.clk_en <= wdata[B_CLKEN];
        st_q.lane   <= wdata[B_LANE +: SEL_W];
      end
      if (byte_we[1]) st_q.rsv[7:0]  <= wdata[RSV_LO +: 8];
      if (byte_we[2]) st_q.rsv[15:8] <= wdata[RSV_LO+8 +: 8];
      if (byte_we[3]) begin
        st_q.ee_ck <= wdata[B_EECLK];
        st_q.ee_cs <= wdata[B_EECS];
        st_q.ee_do <= wdata[B_EEDO];
      end
      if (load_kick)      st_q.reload <= 1'b1;
      else if (load_done) st_q.reload <= 1'b0;
    end
  end

  assign st = st_q;

  always_comb begin
    rdata                      = '0;
    rdata[1:0]                 = strap;
    rdata[B_CLKEN]             = st_q.clk_en;
    rdata[B_LANE +: SEL_W]     = st_q.lane;
    rdata[RSV_LO +: RSV_W]     = st_q.rsv;
    rdata[B_EECLK]             = st_q.ee_ck;
    rdata[B_EECS]              = st_q.ee_cs;
    rdata[B_EEDO]              = st_q.ee_do;
    rdata[B_EEDI]              = ee_di;
    rdata[B_IMGOK]             = img_ok;
    rdata[B_RELOAD]            = st_q.reload;
  end

  logic unused_wbits;
  assign unused_wbits = ^{wdata[31:30], wdata[28:27], wdata[7:5], wdata[1:0]};
endmodule

// File: rtl/lcc_clk_gate.sv
module lcc_clk_gate (
  input  logic clk_src,
  input  logic rst_n,
  input  logic en,
  output logic clk_gated
);
  logic en_lat;

  // Enable captured while the source is low, so the AND never clips a pulse.
  always_ff @(negedge clk_src or negedge rst_n) begin
    if (!rst_n) en_lat <= 1'b0;
    else        en_lat <= en;
  end

  assign clk_gated = clk_src & en_lat;
endmodule

// File: rtl/lcc_lane_steer.sv
module lcc_lane_steer
  import lcc_pkg::*;
(
  input  logic             wide,
  input  logic [SEL_W-1:0] lane,
  input  logic [LCC_W-1:0] host_wdata,
  input  logic [LCC_W-1:0] periph_rdata,
  output logic [LCC_W-1:0] periph_wdata,
  output logic [LCC_W-1:0] host_rdata
);
  logic [LCC_W-1:0]  narrow_rd;
  logic [BYTE_W-1:0] picked;

  for (genvar i = 0; i < N_BYTES; i++) begin : g_lane
    assign narrow_rd[i*BYTE_W +: BYTE_W] =
      (lane == SEL_W'(i)) ? periph_rdata[BYTE_W-1:0] : '0;
  end

  assign picked       = host_wdata[lane*BYTE_W +: BYTE_W];
  assign host_rdata   = wide ? periph_rdata : narrow_rd;
  assign periph_wdata = wide ? host_wdata : {{(LCC_W-BYTE_W){1'b0}}, picked};
endmodule

// File: rtl/lcc_reload_stub.sv
module lcc_reload_stub #(
  parameter int unsigned LOAD_CYCLES = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic done
);
  localparam int unsigned CNT_W = $clog2(LOAD_CYCLES + 1);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (kick)       cnt <= CNT_W'(LOAD_CYCLES);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == CNT_W'(1));
endmodule

// File: rtl/local_ctl_reg.sv
module local_ctl_reg
  import lcc_pkg::*;
#(
  parameter int unsigned LOAD_CYCLES = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_io_wr,
  input  logic        bus_mem_wr,
  input  logic [3:0]  bus_be,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [1:0]  mode_strap,
  output logic        clk_out,
  input  logic        pb_wide,
  input  logic [31:0] pb_rdata,
  output logic [31:0] pb_wdata,
  output logic [31:0] steer_rdata,
  output logic        ee_clk,
  output logic        ee_cs,
  output logic        ee_dout,
  input  logic        ee_din,
  input  logic        ee_image_ok,
  output logic        reload_done
);
  lcc_state_t st;
  logic       kick;
  logic       done;

  lcc_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .io_wr(bus_io_wr), .mem_wr(bus_mem_wr),
    .be(bus_be), .wdata(bus_wdata), .strap(mode_strap), .ee_di(ee_din),
    .img_ok(ee_image_ok), .load_done(done), .st(st), .rdata(bus_rdata),
    .load_kick(kick)
  );

  lcc_clk_gate u_cg (
    .clk_src(clk), .rst_n(rst_n), .en(st.clk_en), .clk_gated(clk_out)
  );

  lcc_lane_steer u_steer (
    .wide(pb_wide), .lane(st.lane), .host_wdata(bus_wdata),
    .periph_rdata(pb_rdata), .periph_wdata(pb_wdata), .host_rdata(steer_rdata)
  );

  lcc_reload_stub #(.LOAD_CYCLES(LOAD_CYCLES)) u_load (
    .clk(clk), .rst_n(rst_n), .kick(kick), .done(done)
  );

  assign ee_clk      = st.ee_ck;
  assign ee_cs       = st.ee_cs;
  assign ee_dout     = st.ee_do;
  assign reload_done = done;

  logic unused_rsv;
  assign unused_rsv = ^st.rsv;
endmodule

// File: rtl/local_ctl_reg_chk.sv
module local_ctl_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_io_wr,
  input logic        bus_mem_wr,
  input logic [3:0]  bus_be,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic [1:0]  mode_strap,
  input logic        pb_wide,
  input logic [31:0] pb_rdata,
  input logic [31:0] pb_wdata,
  input logic [31:0] steer_rdata,
  input logic        ee_clk,
  input logic        ee_cs,
  input logic        ee_dout,
  input logic        reload_done
);
  logic [31:0] lane_mask;
  assign lane_mask = 32'hFF << (bus_rdata[4:3] * 8);

  p_strap_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[1:0] == mode_strap);

  p_narrow_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !pb_wide |-> ((steer_rdata & ~lane_mask) == 32'h0 && pb_wdata[31:8] == 24'h0));

  p_wide_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pb_wide |-> (pb_wdata == bus_wdata && steer_rdata == pb_rdata));

  p_ee_pins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    {ee_dout, ee_cs, ee_clk} == bus_rdata[26:24]);

  p_reload_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata[29] && !reload_done) |=> bus_rdata[29]);

  p_reload_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reload_done |=> !bus_rdata[29]);

  p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[31:30] == 2'b00 && bus_rdata[7:5] == 3'b000);

  p_io_multi_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_io_wr && !bus_mem_wr && $countones(bus_be) != 1)
      |=> (bus_rdata[26:8] == $past(bus_rdata[26:8]) &&
           bus_rdata[4:2]  == $past(bus_rdata[4:2])));
endmodule

bind local_ctl_reg local_ctl_reg_chk u_chk (.*);

// File: tb/local_ctl_reg_bench.sv
`timescale 1ns/1ps
module local_ctl_reg_bench;
  localparam int LOADN = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_io_wr = 1'b0, bus_mem_wr = 1'b0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [1:0]  mode_strap = 2'b10;
  logic        clk_out, pb_wide = 1'b0;
  logic [31:0] pb_rdata = '0, pb_wdata, steer_rdata;
  logic        ee_clk, ee_cs, ee_dout, ee_din = 1'b0, ee_image_ok = 1'b0, reload_done;

  int checks = 0, fails = 0;

  // model state
  logic        m_en = 0;
  logic [1:0]  m_lane = 0;
  logic [15:0] m_rsv = 0;
  logic [2:0]  m_ee = 0;
  logic        m_rl = 0;

  always #5 clk = ~clk;

  local_ctl_reg #(.LOAD_CYCLES(LOADN)) u_local_ctl_reg (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd();
    return {2'b00, m_rl, ee_image_ok, ee_din, m_ee, m_rsv, 3'b000, m_lane, m_en, mode_strap};
  endfunction

  function automatic logic [31:0] exp_steer_rd(input logic w, input logic [1:0] ln, input logic [31:0] d);
    if (w) return d;
    return {24'h0, d[7:0]} << (ln * 8);
  endfunction

  function automatic logic [31:0] exp_steer_wr(input logic w, input logic [1:0] ln, input logic [31:0] d);
    if (w) return d;
    return {24'h0, 8'(d >> (ln * 8))};
  endfunction

  function automatic int ones(input logic [3:0] v);
    return int'(v[0]) + int'(v[1]) + int'(v[2]) + int'(v[3]);
  endfunction

  task automatic model_wr(input logic io, input logic [3:0] be, input logic [31:0] d);
    if (io && ones(be) != 1) return;
    if (be[0]) begin m_en = d[2]; m_lane = d[4:3]; end
    if (be[1]) m_rsv[7:0]  = d[15:8];
    if (be[2]) m_rsv[15:8] = d[23:16];
    if (be[3]) m_ee = d[26:24];
  endtask

  // drive at a falling edge, register at the rising edge, return at the next falling edge
  task automatic bus_write(input logic io, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_io_wr = io; bus_mem_wr = !io; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_io_wr = 0; bus_mem_wr = 0; bus_be = '0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1337));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdata", bus_rdata, exp_rd());
    chk("R1 ee pins", {29'h0, ee_dout, ee_cs, ee_clk}, 32'h0);
    @(posedge clk); #1;
    chk("R1 clk_out low", {31'h0, clk_out}, 32'h0);

    // R3 gate on, then off
    bus_write(0, 4'b0001, 32'h0000_0004); model_wr(0, 4'b0001, 32'h4);
    @(posedge clk); #1;
    chk("R3 clk_out high phase when enabled", {31'h0, clk_out}, 32'h1);
    @(negedge clk); #1;
    chk("R3 clk_out low phase", {31'h0, clk_out}, 32'h0);
    bus_write(1, 4'b0001, 32'h0); model_wr(1, 4'b0001, 32'h0);
    @(posedge clk); #1;
    chk("R3 clk_out held low when disabled", {31'h0, clk_out}, 32'h0);

    // R10 directed: multi-byte I/O write dropped, zero enables dropped
    bus_write(1, 4'b0011, 32'hFFFF_FFFF); model_wr(1, 4'b0011, 32'hFFFF_FFFF);
    chk("R10 io multi-byte ignored", bus_rdata, exp_rd());
    bus_write(1, 4'b0000, 32'hFFFF_FFFF); model_wr(1, 4'b0000, 32'hFFFF_FFFF);
    chk("R10 io no-enable ignored", bus_rdata, exp_rd());
    bus_write(1, 4'b0100, 32'h00A5_0000); model_wr(1, 4'b0100, 32'h00A5_0000);
    chk("R10 io single byte", bus_rdata, exp_rd());

    // R6 / R9 directed
    bus_write(0, 4'b1111, 32'hC7FF_FFE3 & ~32'h2000_0000);
    model_wr(0, 4'b1111, 32'hC7FF_FFE3 & ~32'h2000_0000);
    chk("R9 reserved read zero / storage", bus_rdata, exp_rd());
    chk("R6 ee pins driven", {29'h0, ee_dout, ee_cs, ee_clk}, {29'h0, m_ee});

    // random mixed writes: R2 R6 R7 R9 R10 R11
    for (int i = 0; i < 400; i++) begin
      logic        io;
      logic [3:0]  be;
      logic [31:0] d;
      io = 1'($urandom);
      be = 4'($urandom);
      d  = $urandom & ~32'h2000_0000;
      mode_strap  = 2'($urandom);
      ee_din      = 1'($urandom);
      ee_image_ok = 1'($urandom);
      bus_write(io, be, d); model_wr(io, be, d);
      if (io) chk("R10 io write result", bus_rdata, exp_rd());
      else    chk("R11 mem write result", bus_rdata, exp_rd());
      chk("R6 ee pins", {29'h0, ee_dout, ee_cs, ee_clk}, {29'h0, m_ee});
      mode_strap = 2'($urandom); ee_din = 1'($urandom); ee_image_ok = 1'($urandom);
      #1;
      chk("R2 R7 live bits", {bus_rdata[28:27], bus_rdata[1:0]}, {ee_image_ok, ee_din, mode_strap} );
    end

    // R4 / R5 lane steering all codes both modes
    for (int ln = 0; ln < 4; ln++) begin
      bus_write(0, 4'b0001, {27'h0, 2'(ln), 3'b000}); model_wr(0, 4'b0001, {27'h0, 2'(ln), 3'b000});
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        pb_wide   = k[0];
        pb_rdata  = $urandom;
        bus_wdata = $urandom;
        #1;
        if (pb_wide) begin
          chk("R5 wide read pass", steer_rdata, exp_steer_rd(1, m_lane, pb_rdata));
          chk("R5 wide write pass", pb_wdata, exp_steer_wr(1, m_lane, bus_wdata));
        end else begin
          chk("R4 narrow read lane", steer_rdata, exp_steer_rd(0, m_lane, pb_rdata));
          chk("R4 narrow write lane", pb_wdata, exp_steer_wr(0, m_lane, bus_wdata));
        end
      end
    end
    pb_wide = 0;

    // R8 reload: write 0 does nothing
    bus_write(0, 4'b1000, 32'h0000_0000); model_wr(0, 4'b1000, 32'h0);
    chk("R8 write zero no reload", {31'h0, bus_rdata[29]}, 32'h0);
    // R8 reload length, with a second request mid-load
    begin
      int n;
      int pulses;
      bus_write(0, 4'b1000, 32'h2000_0000); model_wr(0, 4'b1000, 32'h2000_0000);
      n = 1; pulses = 0;
      while (bus_rdata[29] && n < 100) begin
        if (n == 4) begin
          bus_io_wr = 1; bus_be = 4'b1000; bus_wdata = 32'h2000_0000;
        end else begin
          bus_io_wr = 0; bus_be = 4'b0000;
        end
        @(posedge clk); #1;
        if (reload_done) pulses++;
        @(negedge clk);
        if (bus_rdata[29]) n++;
      end
      bus_io_wr = 0; bus_be = '0;
      model_wr(1, 4'b1000, 32'h2000_0000);
      chk("R8 reload busy length", n, LOADN);
      chk("R8 single done pulse", pulses, 1);
      chk("R8 bit self-cleared", {31'h0, bus_rdata[29]}, 32'h0);
    end
    chk("R8 other bits kept", bus_rdata, exp_rd());

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule